// File: doc/BRIEF.md
# Byte-Column Substitution-Mix Unit

This unit computes the round function of two independent AES-style permutations, called P and Q, over a 512-bit state. Each state is an 8×8 byte matrix. The matrix is held in eight byte-wide memories, one per row, and those memories are read in parallel to gather one column.

The row rotation is not done by moving any data. Each row memory is simply read at a column address offset by that row's shift amount. The gathered bytes then go through three steps:

- a round constant is XORed in;
- the bytes pass through four shared S-boxes in two halves;
- a circulant matrix over GF(2^8) mixes the column.

The mixed column is written to the opposite memory bank. Columns of P and Q alternate, and a finished column comes out every 3 cycles.

In normal use the surrounding logic works in four steps. While the unit is idle, it writes both initial states through the load port. It then pulses `start` and waits for `done`. Finally it reads the permuted columns back through the readback port.

Top module: `gcol_round_unit`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls, both `busy` and `done` are low.
- R2: While the unit is idle, a load with `ld_we` high writes `ld_data` as column `ld_col` of the initial state of the permutation selected by `ld_perm` (0 = P, 1 = Q). The row r byte sits on bits 8r+7:8r. While idle, `rd_data` shows the column that `rd_perm`/`rd_col` selected on the previous clock edge, taken from the bank that holds the finished result. With an even round count that bank is the same one that loads write to, so a loaded column reads back unchanged.
- R3: After a run, the P columns equal ROUNDS rounds of the following four steps, in this order:
  - Constant: row 0 of the byte found in column c gets (16·c) XOR round-index.
  - Substitution: every byte goes through the AES S-box, that is, the multiplicative inverse modulo x^8+x^4+x^3+x+1 followed by the AES affine map with constant 0x63.
  - Row shift: output column j, row r, takes the byte from column (j + SHIFT_P[r]) mod 8. The default shifts are 0..7.
  - Mixing: each output byte i is the XOR over k of coef[(k−i) mod 8]·byte k, with coef = (2,2,3,4,5,3,5,7).
- R4: The Q columns follow the same four steps, with two differences. The constant XORs 0xFF into rows 0–6 and (16·c) XOR round-index XOR 0xFF into row 7. The shifts are SHIFT_Q, which default to 1,3,5,7,0,2,4,6.
- R5: The P result depends only on the P input. Changing the Q initial state leaves every P output column unchanged.
- R6: `busy` rises on the edge that captures `start` in idle. `done` rises exactly 1 + 48·ROUNDS clock cycles later.
- R7: A `start` pulse while `busy` is high has no effect: the run keeps its length and its results.
- R8: Load writes while `busy` is high are dropped: the results of the run are unaffected.
- R9: `done` is a one-cycle pulse, and `busy` is low in the same cycle that `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run of both permutations (accepted when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| ld_we | input | 1 | Write one initial-state column (idle only) |
| ld_perm | input | 1 | Load target: 0 = P, 1 = Q |
| ld_col | input | 3 | Column index for the load |
| ld_data | input | 64 | Column bytes, row r on bits 8r+7:8r |
| rd_perm | input | 1 | Readback permutation select |
| rd_col | input | 3 | Readback column index |
| rd_data | output | 64 | Registered readback column (result bank) |

## Verification
The permutation is run on four kinds of state: all zero, a byte ramp, a pseudo-random fill, and a fill where only Q changes while P is held fixed. The all-zero state exercises only the round constants and the S-box fixed behaviour. The ramp separates the rows, so a wrong per-row shift or a wrong constant position shows up. The pseudo-random fill exercises the full multiply table of the mixing step. The changed-Q run tells apart a design that keeps P and Q separate from one that mixes their memory regions. A disturbed run puts stray `start` and load pulses in mid-operation and checks that both the result and the latency stay the same.

// File: rtl/gcol_pkg.sv
package gcol_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 8;               // rows per column and columns per state
  localparam int IDX_W  = $clog2(LANES);
  localparam int HALF   = LANES / 2;       // shared S-box / doubler lanes

  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [1:0] {ST_IDLE, ST_PRIME, ST_RUN} run_st_e;

  // circulant first row, coefficient k at bits [3k+:3]: 2,2,3,4,5,3,5,7
  localparam logic [3*LANES-1:0] MIX_COEF =
    {3'd7, 3'd5, 3'd3, 3'd5, 3'd4, 3'd3, 3'd2, 3'd2};

  function automatic byte_t gf_dbl(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc = '0;
    byte_t x = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = gf_dbl(x);
    end
    return acc;
  endfunction

  // a^254 by square-and-multiply (bits 1..7 of the exponent are set)
  function automatic byte_t gf_inv(input byte_t a);
    byte_t r = 8'h01;
    byte_t p = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic byte_t sbox_fn(input byte_t a);
    byte_t b;
    b = gf_inv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/gcol_bytemem.sv
module gcol_bytemem #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/gcol_sbox.sv
module gcol_sbox
  import gcol_pkg::*;
(
  input  byte_t a,
  output byte_t y
);
  assign y = sbox_fn(a);
endmodule

// File: rtl/gcol_dbl.sv
module gcol_dbl
  import gcol_pkg::*;
(
  input  byte_t a,
  output byte_t x2,
  output byte_t x4
);
  assign x2 = gf_dbl(a);
  assign x4 = gf_dbl(x2);
endmodule

// File: rtl/gcol_ctrl.sv
module gcol_ctrl
  import gcol_pkg::*;
#(
  parameter int ROUNDS = 10,
  parameter int RW     = 4,
  parameter int SW     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [1:0]    ph,
  output logic [SW-1:0] slot,
  output logic [RW-1:0] rnd,
  output logic          rd_go,
  output logic [SW-1:0] rd_slot,
  output logic          rd_bank,
  output logic          wr_go
);
  run_st_e st;
  logic last_slot, last_rnd;

  assign last_slot = (slot == {SW{1'b1}});
  assign last_rnd  = (rnd == RW'(ROUNDS - 1));

  always_comb begin
    rd_go = (st == ST_PRIME) || (st == ST_RUN && ph == 2'd2);
    wr_go = (st == ST_RUN) && (ph == 2'd2);
    if (st == ST_PRIME) begin
      rd_slot = slot;
      rd_bank = rnd[0];
    end else begin
      rd_slot = slot + SW'(1);
      rd_bank = last_slot ? ~rnd[0] : rnd[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; busy <= 1'b0; done <= 1'b0;
      ph <= '0; slot <= '0; rnd <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st <= ST_PRIME; busy <= 1'b1;
          ph <= '0; slot <= '0; rnd <= '0;
        end
        ST_PRIME: st <= ST_RUN;
        default: begin
          if (ph != 2'd2) ph <= ph + 2'd1;
          else begin
            ph   <= '0;
            slot <= slot + SW'(1);
            if (last_slot) begin
              rnd <= rnd + RW'(1);
              if (last_rnd) begin
                st <= ST_IDLE; busy <= 1'b0; done <= 1'b1;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/gcol_round_unit.sv
module gcol_round_unit
  import gcol_pkg::*;
#(
  parameter int ROUNDS = 10,
  parameter logic [IDX_W*LANES-1:0] SHIFT_P =
    {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
  parameter logic [IDX_W*LANES-1:0] SHIFT_Q =
    {3'd6, 3'd4, 3'd2, 3'd0, 3'd7, 3'd5, 3'd3, 3'd1}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  input  logic                    ld_we,
  input  logic                    ld_perm,
  input  logic [IDX_W-1:0]        ld_col,
  input  logic [LANES*BYTE_W-1:0] ld_data,
  input  logic                    rd_perm,
  input  logic [IDX_W-1:0]        rd_col,
  output logic [LANES*BYTE_W-1:0] rd_data
);
  localparam int   RW       = $clog2(ROUNDS + 1);
  localparam int   SW       = IDX_W + 1;       // column index plus P/Q bit
  localparam int   AW       = IDX_W + 2;       // bank, perm, column
  localparam logic FIN_BANK = 1'(ROUNDS % 2);

  logic [1:0]    ph;
  logic [SW-1:0] slot, rd_slot;
  logic [RW-1:0] rnd;
  logic          rd_go, rd_bank, wr_go;

  gcol_ctrl #(.ROUNDS(ROUNDS), .RW(RW), .SW(SW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .ph(ph), .slot(slot), .rnd(rnd), .rd_go(rd_go), .rd_slot(rd_slot),
    .rd_bank(rd_bank), .wr_go(wr_go)
  );

  function automatic logic [IDX_W-1:0] shamt(input logic pm, input int r);
    return pm ? SHIFT_Q[IDX_W*r +: IDX_W] : SHIFT_P[IDX_W*r +: IDX_W];
  endfunction

  // ---- row memories: row shift lives entirely in the read address ----
  logic [AW-1:0]    raddr [LANES];
  logic [AW-1:0]    waddr;
  logic             mem_we, mem_re;
  byte_t            wbyte [LANES];
  byte_t            q     [LANES];
  byte_t            mix   [LANES];

  assign mem_re = rd_go | ~busy;

  always_comb begin
    mem_we = wr_go | (ld_we & ~busy);
    waddr  = busy ? {~rnd[0], slot[0], slot[SW-1:1]} : {1'b0, ld_perm, ld_col};
    for (int r = 0; r < LANES; r++) begin
      raddr[r] = busy ? {rd_bank, rd_slot[0], rd_slot[SW-1:1] + shamt(rd_slot[0], r)}
                      : {FIN_BANK, rd_perm, rd_col};
      wbyte[r] = busy ? mix[r] : ld_data[BYTE_W*r +: BYTE_W];
    end
  end

  for (genvar r = 0; r < LANES; r++) begin : g_row
    gcol_bytemem #(.AW(AW), .DW(BYTE_W)) u_mem (
      .clk(clk), .rst(rst), .we(mem_we), .waddr(waddr), .wdata(wbyte[r]),
      .re(mem_re), .raddr(raddr[r]), .rdata(q[r])
    );
    assign rd_data[BYTE_W*r +: BYTE_W] = q[r];
  end

  // ---- round constant, tied to the column each byte came from ----
  logic [IDX_W-1:0] srccol [LANES];
  byte_t            rc     [LANES];
  byte_t            tag;

  always_comb begin
    for (int r = 0; r < LANES; r++) begin
      srccol[r] = slot[SW-1:1] + shamt(slot[0], r);
      tag       = byte_t'({srccol[r], 4'h0}) ^ byte_t'(rnd);
      if (slot[0]) rc[r] = (r == LANES - 1) ? ~tag : 8'hff;
      else         rc[r] = (r == 0) ? tag : 8'h00;
    end
  end

  // ---- four shared S-boxes and four shared doubling lanes ----
  byte_t sb_in [HALF], sb_out [HALF];
  byte_t db_in [HALF], db2 [HALF], db4 [HALF];
  byte_t sreg  [LANES];
  byte_t d2lo  [HALF], d4lo [HALF];

  for (genvar l = 0; l < HALF; l++) begin : g_lane
    assign sb_in[l] = (ph == 2'd0) ? (q[l] ^ rc[l]) : (q[l+HALF] ^ rc[l+HALF]);
    assign db_in[l] = (ph == 2'd1) ? sreg[l] : sreg[l+HALF];
    gcol_sbox u_sb (.a(sb_in[l]), .y(sb_out[l]));
    gcol_dbl  u_db (.a(db_in[l]), .x2(db2[l]), .x4(db4[l]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LANES; k++) sreg[k] <= '0;
      for (int l = 0; l < HALF; l++) begin d2lo[l] <= '0; d4lo[l] <= '0; end
    end else if (busy) begin
      for (int l = 0; l < HALF; l++) begin
        if (ph == 2'd0) sreg[l] <= sb_out[l];
        if (ph == 2'd1) begin
          sreg[l+HALF] <= sb_out[l];
          d2lo[l]      <= db2[l];
          d4lo[l]      <= db4[l];
        end
      end
    end
  end

  // ---- circulant mix in the third phase ----
  byte_t      m2 [LANES], m4 [LANES];
  logic [2:0] cf;
  int         idx;

  always_comb begin
    for (int k = 0; k < HALF; k++) begin
      m2[k] = d2lo[k];       m4[k] = d4lo[k];
      m2[k+HALF] = db2[k];   m4[k+HALF] = db4[k];
    end
    cf  = '0;
    idx = 0;
    for (int i = 0; i < LANES; i++) begin
      mix[i] = '0;
      for (int k = 0; k < LANES; k++) begin
        idx = (k - i + LANES) % LANES;
        cf  = MIX_COEF[3*idx +: 3];
        if (cf[0]) mix[i] = mix[i] ^ sreg[k];
        if (cf[1]) mix[i] = mix[i] ^ m2[k];
        if (cf[2]) mix[i] = mix[i] ^ m4[k];
      end
    end
  end
endmodule

// File: rtl/gcol_round_chk.sv
module gcol_round_chk
  import gcol_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic mem_we,
  input logic wr_go
);
  localparam int RUN_CYC = ROUNDS * 2 * LANES * 3;
  logic [15:0] cyc;

  always_ff @(posedge clk) begin
    if (rst)       cyc <= '0;
    else if (busy) cyc <= cyc + 16'd1;
    else           cyc <= '0;
  end

  // R6
  run_len_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> cyc == 16'(RUN_CYC + 1));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));
  // R6
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R8
  load_block_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_go) |-> !mem_we);
endmodule

bind gcol_round_unit gcol_round_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .mem_we(mem_we), .wr_go(wr_go)
);

// File: tb/gcol_round_unit_tb_top.sv
module gcol_round_unit_tb_top;
  localparam int ROUNDS = 10;
  localparam int LAT    = 2 + 48 * ROUNDS;  // posedges counted from the start-capturing edge

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic        ld_we = 1'b0, ld_perm = 1'b0, rd_perm = 1'b0;
  logic [2:0]  ld_col = '0, rd_col = '0;
  logic [63:0] ld_data = '0;
  logic [63:0] rd_data;
  logic        busy, done;

  always #5 clk = ~clk;

  gcol_round_unit #(.ROUNDS(ROUNDS)) dut_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .ld_we(ld_we), .ld_perm(ld_perm), .ld_col(ld_col), .ld_data(ld_data),
    .rd_perm(rd_perm), .rd_col(rd_col), .rd_data(rd_data)
  );

  int  vectors = 0, miscompares = 0;
  bit  summary_done = 0;
  logic [63:0] exp_q [$];
  logic [7:0]  sb [256];
  int cf  [8] = '{2, 2, 3, 4, 5, 3, 5, 7};
  int shp [8] = '{0, 1, 2, 3, 4, 5, 6, 7};
  int shq [8] = '{1, 3, 5, 7, 0, 2, 4, 6};
  logic [7:0] stp [8][8], stq [8][8], wk [8][8], tmp [8][8], keep_p [8][8];
  logic [31:0] lcg = 32'h1234_5678;

  task automatic report(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = '0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [63:0] pack(input bit isq, input int c);
    logic [63:0] d;
    for (int r = 0; r < 8; r++) d[8*r +: 8] = isq ? stq[r][c] : stp[r][c];
    return d;
  endfunction

  task automatic model(input bit isq);
    logic [7:0] t, tg, acc;
    for (int rr = 0; rr < ROUNDS; rr++) begin
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 8; r++) begin
          tg = 8'(c * 16) ^ 8'(rr);
          t  = wk[r][c];
          if (!isq) t = t ^ ((r == 0) ? tg : 8'h00);
          else      t = t ^ ((r == 7) ? (tg ^ 8'hff) : 8'hff);
          tmp[r][c] = sb[t];
        end
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++)
          wk[r][c] = tmp[r][(c + (isq ? shq[r] : shp[r])) % 8];
      for (int c = 0; c < 8; c++)
        for (int i = 0; i < 8; i++) begin
          acc = '0;
          for (int k = 0; k < 8; k++) acc = acc ^ bmul(8'(cf[(k - i + 8) % 8]), wk[k][c]);
          tmp[i][c] = acc;
        end
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++) wk[r][c] = tmp[r][c];
    end
  endtask

  // driver: write both states and queue expected results
  task automatic load_all();
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        ld_we = 1'b1; ld_perm = p[0]; ld_col = 3'(c); ld_data = pack(p[0], c);
      end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic push_expected(input bit use_keep);
    logic [63:0] d;
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) wk[r][c] = stp[r][c];
    model(0);
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 8; r++) begin
        d[8*r +: 8] = use_keep ? keep_p[r][c] : wk[r][c];
        keep_p[r][c] = wk[r][c];
      end
      exp_q.push_back(d);
    end
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) wk[r][c] = stq[r][c];
    model(1);
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 8; r++) d[8*r +: 8] = wk[r][c];
      exp_q.push_back(d);
    end
  endtask

  // monitor: read one column and compare with the queue head
  task automatic mon_check(input bit p, input int c, input string req);
    logic [63:0] e;
    @(negedge clk);
    rd_perm = p; rd_col = 3'(c);
    @(negedge clk);
    e = exp_q.pop_front();
    report(rd_data === e, req, rd_data, e);
  endtask

  task automatic run_and_check(input string rp, input string rq, input bit disturb);
    int n = 0;
    @(negedge clk);
    start = 1'b1;
    while (n < 4 * LAT) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start   = disturb && (n == 100);
      ld_we   = disturb && (n >= 150) && (n < 156);
      ld_perm = n[0]; ld_col = 3'(n); ld_data = 64'hdead_beef_0bad_f00d;
      if (done) break;
    end
    ld_we = 1'b0;
    // R6: latency from the capturing edge; R9: busy already low with done
    report(n == LAT, "R6", 64'(n), 64'(LAT));
    report(busy == 1'b0, "R9", 64'(busy), 64'd0);
    @(negedge clk);
    report(done == 1'b0, "R9", 64'(done), 64'd0);
    for (int c = 0; c < 8; c++) mon_check(1'b0, c, rp);
    for (int c = 0; c < 8; c++) mon_check(1'b1, c, rq);
  endtask

  initial begin
    #(2_000_000);
    if (!summary_done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] inv;
    for (int a = 0; a < 256; a++) begin
      inv = '0;
      for (int b = 1; b < 256; b++) if (bmul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      for (int i = 0; i < 8; i++)
        sb[a][i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (8'h63 >> i);
    end

    repeat (3) @(negedge clk);
    report(busy == 1'b0 && done == 1'b0, "R1", {busy, done}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    report(busy == 1'b0 && done == 1'b0, "R1", {busy, done}, 64'd0);

    // R2: idle load and readback of a byte ramp
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) begin
      stp[r][c] = 8'(16 * r + c); stq[r][c] = 8'(8'h80 + 16 * c + r);
    end
    load_all();
    for (int p = 0; p < 2; p++) for (int c = 0; c < 8; c++) exp_q.push_back(pack(p[0], c));
    for (int p = 0; p < 2; p++) for (int c = 0; c < 8; c++) mon_check(p[0], c, "R2");

    // R3/R4 on the ramp just loaded
    push_expected(0);
    run_and_check("R3", "R4", 0);

    // all-zero state
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) begin stp[r][c] = '0; stq[r][c] = '0; end
    load_all(); push_expected(0);
    run_and_check("R3", "R4", 0);

    // pseudo-random fill
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223; stp[r][c] = lcg[31:24];
      lcg = lcg * 32'd1664525 + 32'd1013904223; stq[r][c] = lcg[31:24];
    end
    load_all(); push_expected(0);
    run_and_check("R3", "R4", 0);

    // R5: same P, different Q; P must match the previous P result
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) stq[r][c] = ~stq[r][c] ^ 8'(r + c);
    load_all(); push_expected(1);
    run_and_check("R5", "R4", 0);

    // R7 and R8: stray start and load pulses during the run
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) begin
      stp[r][c] = 8'(37 * r + 11 * c + 5); stq[r][c] = 8'(91 * c + 3 * r);
    end
    load_all(); push_expected(0);
    run_and_check("R7/R8", "R7/R8", 1);

    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule